// File: doc/BRIEF.md
# LED Blink Pattern Sequencer

This block shapes a repeating brightness profile for one LED channel. After its enable goes high it waits a programmable start delay. Then it loops through four phases: a ramp up from a low brightness code to a high brightness code, a hold at the high code, a ramp back down, and a hold at the low code. The loop then returns to the ramp up. The result is an 8-bit brightness code plus a 3-bit phase number. A downstream current-sink stage maps that code to a current.

All timing comes from an external strobe `tick_i`. Each pulse stands for one 16.384 ms time step, and the block counts nothing else. The delay and hold durations use a three-segment code whose step size grows with the code: 1 tick, then 8 ticks, then 32 ticks per code step. The ramp durations use a 3-bit code in which each step doubles the time. While a ramp runs, the output moves in proportion to the elapsed ticks, so the whole ramp fills the selected time. A chip that needs several independent pattern channels places one instance per channel. Each instance has its own enable and comes out of reset disabled.

Top module: `led_pattern_seq`

## Requirements
- R1: The output is level 0 and phase 0 under reset and whenever the enable is low. If the enable falls, both return to 0 one clock later.
- R2: After the enable goes high, the block stays in phase 0 (output 0) for the start-delay duration. On the clock of the tick that completes the delay, it moves to phase 1 with the output at the low code.
- R3: A delay, high-time or low-time code c from 0 to 60 (0x3C) lasts c+1 ticks.
- R4: A code c from 61 to 127 (0x3D to 0x7F) lasts 61 + 8*(c-60) ticks, so 0x7F lasts 597 ticks. The high-time code is 7 bits wide, so it only reaches this segment and the one in R3.
- R5: A delay or low-time code c from 128 to 255 lasts 597 + 32*(c-127) ticks, so 0xFF lasts 4693 ticks.
- R6: A ramp code r from 1 to 7 makes the ramp last 2^(r+3) ticks. After k ticks of a rise, the output is lo + floor((hi-lo)*k/2^(r+3)). After k ticks of a fall, it is hi - floor((hi-lo)*k/2^(r+3)). The last tick of the ramp enters the next hold phase at the target code.
- R7: A ramp with code 0, or any ramp when lo >= hi, lasts exactly one clock and needs no tick.
- R8: Phase 2 outputs the high code for the high-time duration. Phase 4 outputs the low code for the low-time duration.
- R9: Phases follow the order 0 (delay), 1 (rise), 2 (high hold), 3 (fall), 4 (low hold), then 1 again. The output enters phase 3 at the high code.
- R10: The block advances its counts only on clocks where `tick_i` is high. Ticks that arrive while the enable is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock strobe, one 16.384 ms time step |
| en_i | input | 1 | Sequence enable |
| lo_lvl_i | input | 8 | Low brightness code |
| hi_lvl_i | input | 8 | High brightness code |
| delay_code_i | input | 8 | Start-delay duration code |
| high_code_i | input | 7 | High-hold duration code |
| low_code_i | input | 8 | Low-hold duration code |
| rise_code_i | input | 3 | Rise ramp duration code |
| fall_code_i | input | 3 | Fall ramp duration code |
| level_o | output | 8 | Brightness code |
| phase_o | output | 3 | Current phase, 0 to 4 |

## Verification
Each result is registered exactly once. A tick, an enable change or an instant ramp shows up at `level_o` and `phase_o` on the clock edge that samples it. The bench drives every input on a falling edge and samples the outputs on the next falling edge, so each check sees the single edge it targets. Duration checks land on the boundary: one tick before the expected count the phase must not have changed, and on the expected tick it must have. Ramp checks sample after a known number of ticks.

// File: rtl/lps_pkg.sv
// Shared types and duration encodings for the LED pattern sequencer.
// Assumes one tick equals 16.384 ms; all durations are in ticks.
package lps_pkg;

    typedef enum logic [2:0] {
        PH_DELAY = 3'd0,
        PH_RISE  = 3'd1,
        PH_HIGH  = 3'd2,
        PH_FALL  = 3'd3,
        PH_LOW   = 3'd4
    } phase_e;

    localparam int HOLD_W    = 13;
    localparam int SEG1_LAST = 60;
    localparam int SEG2_LAST = 127;
    localparam int SEG2_STEP = 8;
    localparam int SEG3_STEP = 32;
    localparam int SEG2_BASE = SEG1_LAST + 1;
    localparam int SEG3_BASE = SEG2_BASE + (SEG2_LAST - SEG1_LAST) * SEG2_STEP;
    localparam int RAMP_BIAS = 3;

    // Piecewise-linear hold code to tick count.
    function automatic logic [HOLD_W-1:0] hold_ticks(input logic [7:0] code);
        int c;
        int t;
        c = int'(code);
        if (c <= SEG1_LAST)
            t = c + 1;
        else if (c <= SEG2_LAST)
            t = SEG2_BASE + (c - SEG1_LAST) * SEG2_STEP;
        else
            t = SEG3_BASE + (c - SEG2_LAST) * SEG3_STEP;
        return HOLD_W'(t);
    endfunction

    // Successor of each phase in the loop.
    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_DELAY: return PH_RISE;
            PH_RISE:  return PH_HIGH;
            PH_HIGH:  return PH_FALL;
            PH_FALL:  return PH_LOW;
            default:  return PH_RISE;
        endcase
    endfunction

endpackage

// File: rtl/lps_duration_sel.sv
// Selects the hold length in ticks for the current hold-type phase.
// Assumes ramp phases take their length elsewhere; returns 0 for them.
module lps_duration_sel
    import lps_pkg::*;
#(
    parameter int HIGH_W = 7
) (
    input  phase_e              phase_i,
    input  logic [7:0]          delay_code_i,
    input  logic [HIGH_W-1:0]   high_code_i,
    input  logic [7:0]          low_code_i,
    output logic [HOLD_W-1:0]   len_o
);

    // Decode the code that belongs to the present phase.
    always_comb begin
        case (phase_i)
            PH_DELAY: len_o = hold_ticks(delay_code_i);
            PH_HIGH:  len_o = hold_ticks(8'(high_code_i));
            PH_LOW:   len_o = hold_ticks(low_code_i);
            default:  len_o = '0;
        endcase
    end

endmodule

// File: rtl/lps_phase_ctrl.sv
// Phase sequencer: counts ticks within each phase and steps through
// delay, rise, high, fall, low, rise... Assumes tick_i is a one-clock
// strobe and that hold_len_i belongs to the current phase.
module lps_phase_ctrl
    import lps_pkg::*;
#(
    parameter int RCODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                tick_i,
    input  logic                flat_i,
    input  logic [RCODE_W-1:0]  rise_code_i,
    input  logic [RCODE_W-1:0]  fall_code_i,
    input  logic [HOLD_W-1:0]   hold_len_i,
    output phase_e              phase_q_o,
    output phase_e              phase_n_o,
    output logic [HOLD_W-1:0]   cnt_n_o
);

    phase_e              phase_q, phase_n;
    logic [HOLD_W-1:0]   cnt_q, cnt_n, cnt_inc;
    logic [RCODE_W-1:0]  ramp_code;
    logic [HOLD_W-1:0]   ramp_len;
    logic                ramp_now;
    logic                is_ramp;

    // Ramp length for the active ramp phase (power of two ticks).
    always_comb begin
        ramp_code = (phase_q == PH_RISE) ? rise_code_i : fall_code_i;
        ramp_len  = (HOLD_W'(1)) << (int'(ramp_code) + RAMP_BIAS);
        ramp_now  = (ramp_code == '0) || flat_i;
        is_ramp   = (phase_q == PH_RISE) || (phase_q == PH_FALL);
        cnt_inc   = cnt_q + HOLD_W'(1);
    end

    // Next phase and tick count.
    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q;
        if (!en_i) begin
            phase_n = PH_DELAY;
            cnt_n   = '0;
        end else if (is_ramp && ramp_now) begin
            phase_n = next_phase(phase_q);
            cnt_n   = '0;
        end else if (tick_i) begin
            if (cnt_inc >= (is_ramp ? ramp_len : hold_len_i)) begin
                phase_n = next_phase(phase_q);
                cnt_n   = '0;
            end else begin
                cnt_n = cnt_inc;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DELAY;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
        end
    end

    assign phase_q_o = phase_q;
    assign phase_n_o = phase_n;
    assign cnt_n_o   = cnt_n;

    // R1: disable forces the delay phase with a cleared count
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (phase_q == PH_DELAY && cnt_q == '0));

    // R10: holds only move on a tick
    a_r10_hold_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i && !is_ramp) |=> ($stable(phase_q) && $stable(cnt_q)));

    // R9: the high hold may only go to the fall (or back to delay)
    a_r9_high_to_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |=> (phase_q inside {PH_HIGH, PH_FALL, PH_DELAY}));

    // R9: the low hold may only go to the rise (or back to delay)
    a_r9_low_to_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOW) |=> (phase_q inside {PH_LOW, PH_RISE, PH_DELAY}));

    // R9: the delay may only lead to the rise
    a_r9_delay_to_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DELAY) |=> (phase_q inside {PH_DELAY, PH_RISE}));

endmodule

// File: rtl/lps_level_shaper.sv
// Brightness shaper: registers the output code for the phase and tick
// count the sequencer moves to. Ramps are interpolated as
// span*k >> (code+3); assumes k never exceeds the ramp length.
module lps_level_shaper
    import lps_pkg::*;
#(
    parameter int LVL_W   = 8,
    parameter int RCODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LVL_W-1:0]    lo_i,
    input  logic [LVL_W-1:0]    hi_i,
    input  logic [RCODE_W-1:0]  rise_code_i,
    input  logic [RCODE_W-1:0]  fall_code_i,
    input  phase_e              phase_n_i,
    input  logic [HOLD_W-1:0]   cnt_n_i,
    output logic                flat_o,
    output logic [LVL_W-1:0]    level_o
);

    localparam int PROD_W = LVL_W + HOLD_W;

    logic [LVL_W-1:0]   span;
    logic [RCODE_W-1:0] code;
    logic [PROD_W-1:0]  prod;
    logic [LVL_W-1:0]   delta;
    logic [LVL_W-1:0]   level_d;
    logic [LVL_W-1:0]   level_q;

    // Span between the two levels; zero when the levels do not rise.
    always_comb begin
        flat_o = (lo_i >= hi_i);
        span   = flat_o ? '0 : (hi_i - lo_i);
    end

    // Proportional ramp offset for the elapsed tick count.
    always_comb begin
        code  = (phase_n_i == PH_RISE) ? rise_code_i : fall_code_i;
        prod  = PROD_W'(span) * PROD_W'(cnt_n_i);
        delta = LVL_W'(prod >> (int'(code) + RAMP_BIAS));
    end

    // Output code for the next phase.
    always_comb begin
        case (phase_n_i)
            PH_RISE: level_d = lo_i + delta;
            PH_HIGH: level_d = hi_i;
            PH_FALL: level_d = hi_i - delta;
            PH_LOW:  level_d = lo_i;
            default: level_d = '0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level_o = level_q;

    // R6: the offset never leaves the span between the levels
    a_r6_delta_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_n_i == PH_RISE || phase_n_i == PH_FALL) |-> (delta <= span));

endmodule

// File: rtl/led_pattern_seq.sv
// LED blink pattern sequencer top: ties the duration decoder, the phase
// sequencer and the level shaper together. Assumes tick_i is a
// one-clock strobe per 16.384 ms and the codes are held while in use.
module led_pattern_seq
    import lps_pkg::*;
#(
    parameter int LVL_W   = 8,
    parameter int HIGH_W  = 7,
    parameter int RCODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                en_i,
    input  logic [LVL_W-1:0]    lo_lvl_i,
    input  logic [LVL_W-1:0]    hi_lvl_i,
    input  logic [7:0]          delay_code_i,
    input  logic [HIGH_W-1:0]   high_code_i,
    input  logic [7:0]          low_code_i,
    input  logic [RCODE_W-1:0]  rise_code_i,
    input  logic [RCODE_W-1:0]  fall_code_i,
    output logic [LVL_W-1:0]    level_o,
    output logic [2:0]          phase_o
);

    phase_e             phase_q, phase_n;
    logic [HOLD_W-1:0]  hold_len;
    logic [HOLD_W-1:0]  cnt_n;
    logic               flat;

    lps_duration_sel #(.HIGH_W(HIGH_W)) u_dur (
        .phase_i      (phase_q),
        .delay_code_i (delay_code_i),
        .high_code_i  (high_code_i),
        .low_code_i   (low_code_i),
        .len_o        (hold_len)
    );

    lps_phase_ctrl #(.RCODE_W(RCODE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .tick_i       (tick_i),
        .flat_i       (flat),
        .rise_code_i  (rise_code_i),
        .fall_code_i  (fall_code_i),
        .hold_len_i   (hold_len),
        .phase_q_o    (phase_q),
        .phase_n_o    (phase_n),
        .cnt_n_o      (cnt_n)
    );

    lps_level_shaper #(.LVL_W(LVL_W), .RCODE_W(RCODE_W)) u_shape (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_i         (lo_lvl_i),
        .hi_i         (hi_lvl_i),
        .rise_code_i  (rise_code_i),
        .fall_code_i  (fall_code_i),
        .phase_n_i    (phase_n),
        .cnt_n_i      (cnt_n),
        .flat_o       (flat),
        .level_o      (level_o)
    );

    assign phase_o = phase_q;

    // R1: disabled output is dark and in the delay phase
    a_r1_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (level_o == '0 && phase_o == 3'd0));

    // R2: the delay phase always shows level 0
    a_r2_delay_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DELAY) |-> (level_o == '0));

    // R8: the high hold shows the high code of the previous cycle
    a_r8_high_level: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |-> (level_o == $past(hi_lvl_i)));

    // R6: a rise with steady levels never steps down
    a_r6_rise_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RISE && $past(phase_q) == PH_RISE &&
         $past(lo_lvl_i, 1) == $past(lo_lvl_i, 2) &&
         $past(hi_lvl_i, 1) == $past(hi_lvl_i, 2))
        |-> (level_o >= $past(level_o)));

endmodule

// File: tb/led_pattern_seq_bench.sv
// Directed bench for the LED pattern sequencer.
module led_pattern_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic [7:0] lo = 8'd0;
    logic [7:0] hi = 8'd0;
    logic [7:0] dly = 8'd0;
    logic [6:0] hcode = 7'd0;
    logic [7:0] lcode = 8'd0;
    logic [2:0] rcode = 3'd0;
    logic [2:0] fcode = 3'd0;
    logic [7:0] level;
    logic [2:0] phase;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    led_pattern_seq u_led_pattern_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .en_i         (en),
        .lo_lvl_i     (lo),
        .hi_lvl_i     (hi),
        .delay_code_i (dly),
        .high_code_i  (hcode),
        .low_code_i   (lcode),
        .rise_code_i  (rcode),
        .fall_code_i  (fcode),
        .level_o      (level),
        .phase_o      (phase)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic restart();
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
    endtask

    // R1: state out of reset
    task automatic t_reset();
        clk_n(3);
        rst_n = 1'b1;
        clk_n(2);
        check("R1 reset level", level, 0);
        check("R1 reset phase", phase, 0);
    endtask

    // R2-R5: delay length for one code, checked on both sides of the boundary
    task automatic t_delay_len(input logic [7:0] code, input int n, input string req);
        lo = 8'd5; hi = 8'd250; rcode = 3'd7; dly = code;
        restart();
        if (n > 1) tick_n(n - 1);
        check({req, " still delay"}, phase, 0);
        check({req, " dark in delay"}, level, 0);
        tick_n(1);
        check({req, " enters rise"}, phase, 1);
        check({req, " rise starts at low"}, level, 5);
    endtask

    // R4, R8, R9, R7: long high hold, instant ramps, loop back to rise
    task automatic t_hold_loop();
        lo = 8'd10; hi = 8'd200; dly = 8'd0; rcode = 3'd0; fcode = 3'd0;
        hcode = 7'h7F; lcode = 8'd1;
        restart();
        tick_n(1);
        check("R2 rise after one tick", phase, 1);
        clk_n(1);
        check("R7 instant rise to high", phase, 2);
        check("R8 high level", level, 200);
        tick_n(596);
        check("R4 high 0x7F not done at 596", phase, 2);
        tick_n(1);
        check("R4 high 0x7F done at 597", phase, 3);
        check("R9 fall starts at high", level, 200);
        clk_n(1);
        check("R7 instant fall to low", phase, 4);
        check("R8 low level", level, 10);
        tick_n(1);
        check("R3 low code 1 holds", phase, 4);
        tick_n(1);
        check("R9 low loops to rise", phase, 1);
        check("R9 rise restarts at low", level, 10);
    endtask

    // R6: proportional ramps, short and long
    task automatic t_ramps();
        lo = 8'd10; hi = 8'd200; dly = 8'd0; rcode = 3'd1; fcode = 3'd2;
        hcode = 7'd0; lcode = 8'd0;
        restart();
        tick_n(1);
        check("R6 rise at k=0", level, 10);
        tick_n(1);
        check("R6 rise at k=1", level, 21);
        tick_n(7);
        check("R6 rise at k=8", level, 105);
        tick_n(7);
        check("R6 rise at k=15", level, 188);
        check("R6 still rising at k=15", phase, 1);
        tick_n(1);
        check("R6 rise ends in high", phase, 2);
        check("R6 rise ends at high", level, 200);
        tick_n(1);
        check("R9 high to fall", phase, 3);
        tick_n(16);
        check("R6 fall at k=16", level, 105);
        tick_n(16);
        check("R6 fall ends in low", phase, 4);
        check("R6 fall ends at low", level, 10);
        lo = 8'd0; hi = 8'd255; rcode = 3'd7;
        restart();
        tick_n(1);
        tick_n(512);
        check("R6 long rise at half", level, 127);
        tick_n(511);
        check("R6 long rise not done", phase, 1);
        tick_n(1);
        check("R6 long rise done", phase, 2);
    endtask

    // R7: low not below high gives instant ramps
    task automatic t_flat();
        lo = 8'd150; hi = 8'd100; dly = 8'd0; rcode = 3'd3; fcode = 3'd3;
        hcode = 7'd0; lcode = 8'd0;
        restart();
        tick_n(1);
        check("R7 flat rise entry", level, 150);
        clk_n(1);
        check("R7 flat rise one clock", phase, 2);
        check("R7 flat high value", level, 100);
        tick_n(1);
        check("R7 flat fall entry", phase, 3);
        clk_n(1);
        check("R7 flat fall one clock", phase, 4);
        check("R7 flat low value", level, 150);
    endtask

    // R1, R10: disable mid-run, ticks while off, no motion without ticks
    task automatic t_disable();
        lo = 8'd20; hi = 8'd90; dly = 8'd2; rcode = 3'd0; fcode = 3'd0;
        hcode = 7'd3; lcode = 8'd3;
        restart();
        tick_n(3);
        clk_n(1);
        check("R10 setup in high", phase, 2);
        clk_n(50);
        check("R10 no tick no move", phase, 2);
        check("R10 no tick level", level, 90);
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        check("R1 disable level", level, 0);
        check("R1 disable phase", phase, 0);
        tick_n(5);
        check("R10 ticks while off phase", phase, 0);
        check("R10 ticks while off level", level, 0);
        @(negedge clk) en = 1'b1;
        tick_n(2);
        check("R2 restart delay holds", phase, 0);
        tick_n(1);
        check("R2 restart delay done", phase, 1);
    endtask

    initial begin
        t_reset();
        t_delay_len(8'h00, 1, "R3 code 0x00");
        t_delay_len(8'h3C, 61, "R3 code 0x3C");
        t_delay_len(8'h3D, 69, "R4 code 0x3D");
        t_delay_len(8'h7F, 597, "R4 code 0x7F");
        t_delay_len(8'h80, 629, "R5 code 0x80");
        t_delay_len(8'hFF, 4693, "R5 code 0xFF");
        t_hold_loop();
        t_ramps();
        t_flat();
        t_disable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule